// File: doc/BRIEF.md
# Learning Dead-Time Controller for a Synchronous Buck Stage

This block turns one raw PWM bit into two gate commands, one for the high-side switch and one for the low-side switch, and it never drives both at once. Between one gate switching off and the other switching on it holds both commands low for a dead interval counted in clock ticks. Each of the two transitions has its own dead-time register. One covers the low-to-high handover and the other covers the high-to-low handover.

In predictive mode each dead-time register tunes itself once per switching cycle. During the dead interval a comparator flag reports whether the switch node has fallen below a small negative threshold, which means a body diode is conducting. If that happens at any time in the interval, the next interval on the same edge is one tick shorter. If it does not happen, the next interval is one tick longer. Both values stay between programmable limits.

When the converter sinks current the switch node does not swing negative, so the flag carries no information. In that case the block stops learning and ends each dead interval on feedback from the driver instead. The new gate turns on as soon as the opposite gate reports that it is off.

Top module: `deadtime_ctrl`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, both gate commands are low and both dead-time outputs equal DT_MAX. After release the block is in a dead interval leading to the low-side gate.
- R2: hs_on and ls_on are never high in the same cycle. Every rise of either command follows at least one cycle in which both commands were low.
- R3: In predictive mode (mode_sink low), a rise of pwm_in while the low-side gate is on produces exactly hs_dead_ticks cycles with both gates low, and then hs_on rises. A fall of pwm_in while the high-side gate is on produces exactly ls_dead_ticks cycles with both gates low, and then ls_on rises.
- R4: If phase_neg is high in any cycle of a completed predictive dead interval, that edge's dead-time value drops by one when the new gate turns on. It never goes below DT_MIN.
- R5: If phase_neg stays low for a whole completed predictive dead interval, that edge's dead-time value rises by one when the new gate turns on. It never goes above DT_MAX.
- R6: Each interval updates only its own edge's value. hs_dead_ticks belongs to the interval before hs_on, and ls_dead_ticks belongs to the interval before ls_on. The other value stays unchanged.
- R7: While mode_sink is high, the interval before hs_on ends in the cycle after ls_gate_off_fb is seen high, and the interval before ls_on ends in the cycle after hs_gate_off_fb is seen high. phase_neg is ignored, and neither dead-time value changes.
- R8: If pwm_in returns to its old level before a dead interval has completed, the gate that was on before turns back on in the next cycle. Neither dead-time value changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock that counts dead time |
| rst_n | input | 1 | Active-low synchronous reset |
| pwm_in | input | 1 | Raw PWM demand, 1 = high side on |
| phase_neg | input | 1 | Switch node below the negative diode threshold |
| hs_gate_off_fb | input | 1 | High-side driver reports its gate is off |
| ls_gate_off_fb | input | 1 | Low-side driver reports its gate is off |
| mode_sink | input | 1 | Converter is sinking current: use feedback timing |
| hs_on | output | 1 | High-side gate command |
| ls_on | output | 1 | Low-side gate command |
| hs_dead_ticks | output | $clog2(DT_MAX+1) | Dead time before the high side turns on |
| ls_dead_ticks | output | $clog2(DT_MAX+1) | Dead time before the low side turns on |

## Verification
The assertions assume the reset is applied with pwm_in low. They also assume that mode_sink stays at one level for a whole dead interval, and that gate-off feedback pulses arrive only while a sink-mode interval is waiting for them. The stimulus changes every input on the falling clock edge and sets mode_sink before a PWM edge, holding it until the new gate is on. Each feedback pulse lasts one cycle, and pwm_in is held for several cycles after every turn-on. In the PWM-reversal case, pwm_in flips back one cycle into the interval, while the dead time in effect for that edge is at least two ticks.

// File: rtl/dtc_pkg.sv
package dtc_pkg;

    // Bit 0 set marks a dead interval; bit 1 names the gate that comes next.
    typedef enum logic [1:0] {
        ST_LS_ON  = 2'b00,
        ST_GAP_LS = 2'b01,
        ST_HS_ON  = 2'b10,
        ST_GAP_HS = 2'b11
    } dtc_state_e;

    localparam int EDGE_HS = 0;
    localparam int EDGE_LS = 1;
    localparam int N_EDGES = 2;

endpackage

// File: rtl/dtc_gap_meter.sv
module dtc_gap_meter #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             phase_neg,
    output logic [CNT_W-1:0] cnt,
    output logic             seen
);

    localparam logic [CNT_W-1:0] CNT_TOP = '1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             seen;
    } meter_t;

    meter_t m_d, m_q;

    always_comb begin
        m_d = m_q;
        if (clr) begin
            m_d.cnt  = '0;
            m_d.seen = 1'b0;
        end else begin
            if (m_q.cnt != CNT_TOP) begin
                m_d.cnt = m_q.cnt + 1'b1;
            end
            m_d.seen = m_q.seen | phase_neg;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m_q <= '0;
        end else begin
            m_q <= m_d;
        end
    end

    assign cnt  = m_q.cnt;
    assign seen = m_q.seen;

    // R4: the diode flag is cleared whenever the meter is cleared
    a_r4_seen_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (!seen && cnt == '0));

endmodule

// File: rtl/dtc_edge_track.sv
module dtc_edge_track #(
    parameter int DT_W   = 4,
    parameter int DT_MIN = 2,
    parameter int DT_MAX = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            upd,
    input  logic            shrink,
    output logic [DT_W-1:0] dt
);

    localparam logic [DT_W-1:0] MIN_V = DT_W'(DT_MIN);
    localparam logic [DT_W-1:0] MAX_V = DT_W'(DT_MAX);

    logic [DT_W-1:0] dt_d, dt_q;

    always_comb begin
        dt_d = dt_q;
        if (upd) begin
            if (shrink) begin
                dt_d = (dt_q > MIN_V) ? dt_q - 1'b1 : MIN_V;
            end else begin
                dt_d = (dt_q < MAX_V) ? dt_q + 1'b1 : MAX_V;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dt_q <= MAX_V;
        end else begin
            dt_q <= dt_d;
        end
    end

    assign dt = dt_q;

    // R4, R5: value stays inside the programmed window
    a_r5_within_limits: assert property (@(posedge clk) disable iff (!rst_n)
        (dt >= MIN_V) && (dt <= MAX_V));

    // R4, R5: each change is a single tick
    a_r4_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dt) |-> (dt == $past(dt) + 1'b1) || (dt + 1'b1 == $past(dt)));

    // R6: without an update request the value holds
    a_r6_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |=> $stable(dt));

endmodule

// File: rtl/deadtime_ctrl.sv
module deadtime_ctrl
    import dtc_pkg::*;
#(
    parameter  int DT_MIN = 2,
    parameter  int DT_MAX = 12,
    localparam int DT_W   = $clog2(DT_MAX + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pwm_in,
    input  logic            phase_neg,
    input  logic            hs_gate_off_fb,
    input  logic            ls_gate_off_fb,
    input  logic            mode_sink,
    output logic            hs_on,
    output logic            ls_on,
    output logic [DT_W-1:0] hs_dead_ticks,
    output logic [DT_W-1:0] ls_dead_ticks
);

    typedef struct packed {
        dtc_state_e st;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [DT_W-1:0]    gap_cnt;
    logic               gap_seen;
    logic [N_EDGES-1:0] upd;
    logic               shrink;
    logic [DT_W-1:0]    dt_arr [N_EDGES];
    logic [DT_W-1:0]    dt_sel;
    logic [DT_W:0]      cnt_next;
    logic               gap_done;
    logic               in_gap_q;

    assign in_gap_q = ctl_q.st[0];
    assign shrink   = gap_seen | phase_neg;
    assign dt_sel   = (ctl_q.st == ST_GAP_HS) ? dt_arr[EDGE_HS] : dt_arr[EDGE_LS];
    assign cnt_next = {1'b0, gap_cnt} + (DT_W + 1)'(1);
    assign gap_done = cnt_next >= {1'b0, dt_sel};

    dtc_gap_meter #(
        .CNT_W (DT_W)
    ) u_meter (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (!in_gap_q),
        .phase_neg (phase_neg),
        .cnt       (gap_cnt),
        .seen      (gap_seen)
    );

    for (genvar e = 0; e < N_EDGES; e++) begin : g_edge
        dtc_edge_track #(
            .DT_W   (DT_W),
            .DT_MIN (DT_MIN),
            .DT_MAX (DT_MAX)
        ) u_track (
            .clk    (clk),
            .rst_n  (rst_n),
            .upd    (upd[e]),
            .shrink (shrink),
            .dt     (dt_arr[e])
        );
    end

    always_comb begin
        ctl_d = ctl_q;
        upd   = '0;
        unique case (ctl_q.st)
            ST_LS_ON: begin
                if (pwm_in) ctl_d.st = ST_GAP_HS;
            end
            ST_HS_ON: begin
                if (!pwm_in) ctl_d.st = ST_GAP_LS;
            end
            ST_GAP_HS: begin
                if (!pwm_in) begin
                    ctl_d.st = ST_LS_ON;
                end else if (mode_sink) begin
                    if (ls_gate_off_fb) ctl_d.st = ST_HS_ON;
                end else if (gap_done) begin
                    ctl_d.st      = ST_HS_ON;
                    upd[EDGE_HS]  = 1'b1;
                end
            end
            ST_GAP_LS: begin
                if (pwm_in) begin
                    ctl_d.st = ST_HS_ON;
                end else if (mode_sink) begin
                    if (hs_gate_off_fb) ctl_d.st = ST_LS_ON;
                end else if (gap_done) begin
                    ctl_d.st      = ST_LS_ON;
                    upd[EDGE_LS]  = 1'b1;
                end
            end
            default: ctl_d.st = ST_GAP_LS;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q.st <= ST_GAP_LS;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign hs_on         = (ctl_q.st == ST_HS_ON);
    assign ls_on         = (ctl_q.st == ST_LS_ON);
    assign hs_dead_ticks = dt_arr[EDGE_HS];
    assign ls_dead_ticks = dt_arr[EDGE_LS];

    // R2: the two gate commands never overlap
    a_r2_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_on && ls_on));

    // R2: a turn-on always follows a cycle with both gates off
    a_r2_gap_before_hs: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_on) |-> !$past(ls_on));

    a_r2_gap_before_ls: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ls_on) |-> !$past(hs_on));

    // R7: in sink mode no dead-time value is learned
    a_r7_sink_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (in_gap_q && mode_sink) |=> ($stable(hs_dead_ticks) && $stable(ls_dead_ticks)));

    // R6: the high-side interval leaves the low-side value alone
    a_r6_hs_gap_keeps_ls: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_GAP_HS) |=> $stable(ls_dead_ticks));

    a_r6_ls_gap_keeps_hs: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_GAP_LS) |=> $stable(hs_dead_ticks));

endmodule

// File: tb/deadtime_ctrl_tb.sv
module deadtime_ctrl_tb;

    localparam int TB_MIN = 2;
    localparam int TB_MAX = 6;
    localparam int TB_W   = $clog2(TB_MAX + 1);
    localparam int HOLD   = 3;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            pwm_in = 1'b0;
    logic            phase_neg = 1'b0;
    logic            hs_gate_off_fb = 1'b0;
    logic            ls_gate_off_fb = 1'b0;
    logic            mode_sink = 1'b0;
    logic            hs_on, ls_on;
    logic [TB_W-1:0] hs_dead_ticks, ls_dead_ticks;

    always #4 clk = ~clk;

    deadtime_ctrl #(
        .DT_MIN (TB_MIN),
        .DT_MAX (TB_MAX)
    ) u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .pwm_in         (pwm_in),
        .phase_neg      (phase_neg),
        .hs_gate_off_fb (hs_gate_off_fb),
        .ls_gate_off_fb (ls_gate_off_fb),
        .mode_sink      (mode_sink),
        .hs_on          (hs_on),
        .ls_on          (ls_on),
        .hs_dead_ticks  (hs_dead_ticks),
        .ls_dead_ticks  (ls_dead_ticks)
    );

    typedef struct {
        bit    to_hs;
        int    gap;
        int    hs_dt;
        int    ls_dt;
        string req;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   errors = 0;
    int   m_hs = TB_MAX;
    int   m_ls = TB_MAX;
    bit   finished = 1'b0;

    task automatic chk(input string req, input int act, input int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic int learn(input int v, input bit diode);
        if (diode) return (v > TB_MIN) ? v - 1 : TB_MIN;
        return (v < TB_MAX) ? v + 1 : TB_MAX;
    endfunction

    // Predictive edge: gap equals the edge's current value, then it learns.
    task automatic pred_edge(input bit to_hs, input bit diode, input string req);
        exp_t e;
        int   gap;
        @(negedge clk);
        pwm_in    = to_hs;
        phase_neg = diode;
        gap = to_hs ? m_hs : m_ls;
        if (to_hs) m_hs = learn(m_hs, diode);
        else       m_ls = learn(m_ls, diode);
        e.to_hs = to_hs; e.gap = gap; e.hs_dt = m_hs; e.ls_dt = m_ls; e.req = req;
        exp_q.push_back(e);
        repeat (gap + 1) @(negedge clk);
        phase_neg = 1'b0;
        repeat (HOLD) @(negedge clk);
    endtask

    // Sink edge: the interval lasts until the opposite gate reports off.
    task automatic sink_edge(input bit to_hs, input int wait_w, input string req);
        exp_t e;
        @(negedge clk);
        pwm_in    = to_hs;
        mode_sink = 1'b1;
        phase_neg = 1'b1;
        e.to_hs = to_hs; e.gap = wait_w; e.hs_dt = m_hs; e.ls_dt = m_ls; e.req = req;
        exp_q.push_back(e);
        repeat (wait_w) @(negedge clk);
        if (to_hs) ls_gate_off_fb = 1'b1;
        else       hs_gate_off_fb = 1'b1;
        @(negedge clk);
        ls_gate_off_fb = 1'b0;
        hs_gate_off_fb = 1'b0;
        mode_sink      = 1'b0;
        phase_neg      = 1'b0;
        repeat (HOLD) @(negedge clk);
    endtask

    // Monitor: measures each dead gap and compares it against the queue.
    initial begin : monitor
        int gap;
        bit prev_on;
        bit first;
        gap = 0; prev_on = 1'b0; first = 1'b1;
        forever begin
            @(posedge clk);
            #2;
            if (!rst_n) begin
                gap = 0; prev_on = 1'b0; first = 1'b1;
            end else begin
                if (hs_on && ls_on) chk("R2 overlap", 1, 0);
                if ((hs_on || ls_on) && !prev_on) begin
                    if (first) begin
                        first = 1'b0;
                    end else if (exp_q.size() == 0) begin
                        chk("R2 unexpected turn-on", 1, 0);
                    end else begin
                        exp_t e;
                        e = exp_q.pop_front();
                        chk({e.req, " gate"}, int'(hs_on), int'(e.to_hs));
                        chk({e.req, " gap"}, gap, e.gap);
                        chk({e.req, " hs_dead_ticks"}, int'(hs_dead_ticks), e.hs_dt);
                        chk({e.req, " ls_dead_ticks"}, int'(ls_dead_ticks), e.ls_dt);
                    end
                    gap = 0;
                end
                if (!(hs_on || ls_on)) gap++;
                prev_on = hs_on || ls_on;
            end
        end
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : driver
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 hs_on in reset", int'(hs_on), 0);
        chk("R1 ls_on in reset", int'(ls_on), 0);
        chk("R1 hs_dead_ticks in reset", int'(hs_dead_ticks), TB_MAX);
        chk("R1 ls_dead_ticks in reset", int'(ls_dead_ticks), TB_MAX);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 outputs off after release", int'(hs_on || ls_on), 0);
        wait (ls_on);
        repeat (HOLD) @(negedge clk);

        pred_edge(1'b1, 1'b0, "R5 max saturate hs");
        pred_edge(1'b0, 1'b1, "R4 shrink ls");
        pred_edge(1'b1, 1'b1, "R4 shrink hs");
        for (int i = 0; i < 4; i++) begin
            pred_edge(1'b0, 1'b1, "R3 R4 ls walk down");
            pred_edge(1'b1, 1'b1, "R3 R4 hs walk down");
        end
        pred_edge(1'b0, 1'b0, "R5 grow ls from min");
        pred_edge(1'b1, 1'b1, "R4 min saturate hs");
        pred_edge(1'b0, 1'b1, "R6 ls alone");
        pred_edge(1'b1, 1'b0, "R5 grow hs");
        pred_edge(1'b0, 1'b0, "R5 grow ls");

        sink_edge(1'b1, 4, "R7 sink to hs");
        sink_edge(1'b0, 1, "R7 sink to ls short");
        sink_edge(1'b1, 8, "R7 sink to hs long");
        sink_edge(1'b0, 2, "R7 sink to ls");

        // R8: pwm reverts one cycle into the high-side interval
        begin
            exp_t e;
            @(negedge clk);
            pwm_in    = 1'b1;
            phase_neg = 1'b1;
            e.to_hs = 1'b0; e.gap = 1; e.hs_dt = m_hs; e.ls_dt = m_ls; e.req = "R8 abort";
            exp_q.push_back(e);
            @(negedge clk);
            pwm_in    = 1'b0;
            phase_neg = 1'b0;
            repeat (HOLD + 2) @(negedge clk);
        end

        pred_edge(1'b1, 1'b0, "R3 after abort hs");
        pred_edge(1'b0, 1'b1, "R3 after abort ls");

        repeat (20) @(negedge clk);
        chk("R3 scoreboard drained", exp_q.size(), 0);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule